// File: doc/BRIEF.md
# Chained Interval Timer Unit

This block holds three 16-bit down-counters that software programs through one byte-wide register port. Counter 2 is stepped by every cycle of the master clock and acts as a prescaler: each of its terminal counts becomes a single-cycle step enable for counters 0 and 1. Counter 0 is intended as the periodic system tick, and counter 1 as a free-running timekeeping counter whose wrap raises a second interrupt.

Each counter is set up by a control write that selects the counter, the word access and the mode. Two data writes follow, low byte first. Software can freeze a counter's value with a latch command and read it back in two byte reads. A write-one-to-clear register acknowledges the two sticky interrupt flags.

Register addresses: 0, 1 and 2 are the data registers of counters 0, 1 and 2, 3 is the control register and 4 is the clear register. Reads from addresses 3 and 4 return zero.

Top module: `chained_timer_unit`

## Requirements
- R1: After reset both interrupt outputs are 0, every counter is stopped, and data reads return 0.
- R2: The control byte is laid out as bits 7:6 counter select (0 to 2; 3 is ignored), bits 5:4 access (00 latch, 11 low-then-high word), and bits 3:1 mode (010 rate generator, 100 software strobe). A word-access control write stops the selected counter. The counter starts only when the high byte of its reload value has been written, and the low byte alone never starts it.
- R3: In rate-generator mode the counter reloads its programmed value at each terminal count and keeps running, so one period is exactly the reload value in steps.
- R4: Counter 2 steps on every clock. Counters 0 and 1 step only in cycles where counter 2 reaches terminal count, so the tick period is the product of the two reload values, in clocks.
- R5: irq_tick is set by the terminal count of counter 0, and irq_wrap by the terminal count of counter 1. Each flag stays set until it is cleared.
- R6: A write to the clear register with bit 0 set clears irq_tick, and one with bit 1 set clears irq_wrap. A clear bit of 0 leaves its flag unchanged, and 0x03 clears both.
- R7: When a terminal count and a clear of the same flag fall in the same cycle, the flag ends up set.
- R8: A latch command freezes the selected counter's current value. The next two reads of that counter return the frozen low byte and then the frozen high byte, while the counter keeps running.
- R9: A word-access control write that selects software-strobe mode stops the counter, and it produces no further interrupts after its reload bytes are written.
- R10: The smallest supported divisor, a reload of 2, gives a period of 2 steps on both the prescaler and counter 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; also the step source of counter 2 |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; advances the byte pointer of a data register |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for the current address, combinational |
| irq_tick | output | 1 | Sticky flag from the counter 0 terminal count |
| irq_wrap | output | 1 | Sticky flag from the counter 1 terminal count |

## Verification
The bench measures the gap between two successive flag sets. A design with an off-by-one reload would give a tick period of 14 or 16 clocks instead of 15, or 3 or 5 instead of 4 at the divisor-2 corner. It also lands a clear on the exact cycle of a terminal count, where a clear-wins priority would drop an interrupt. Further tests write only the low byte of a reload value and stop a counter with the strobe mode; a design that starts early or keeps running would raise irq_tick there. The latch test checks an exact frozen count a few cycles after it was captured, which a design that returns the live value or swaps the byte order would fail.

// File: rtl/ctu_pkg.sv
package ctu_pkg;

    localparam int CNT_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int NUM_CNT = 3;
    localparam int ADDR_W  = 3;
    localparam int NUM_IRQ = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] ADDR_CLR  = ADDR_W'(4);

    localparam logic [2:0] MODE_RATE   = 3'b010;
    localparam logic [2:0] MODE_STROBE = 3'b100;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_WORD  = 2'b11
    } ctu_acc_e;

    typedef struct packed {
        logic [1:0] sel;
        ctu_acc_e   acc;
        logic [2:0] mode;
        logic       rsv;
    } ctu_ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] snap;
        logic             snap_ok;
        logic             running;
        logic             periodic;
        logic             wr_hi;
        logic             rd_hi;
    } ctu_cnt_state_t;

    function automatic logic [BYTE_W-1:0] pick_byte(logic [CNT_W-1:0] v, logic hi);
        return hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/ctu_counter.sv
module ctu_counter
    import ctu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  ctu_acc_e          cfg_acc,
    input  logic [2:0]        cfg_mode,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              step,
    output logic [BYTE_W-1:0] rdata,
    output logic              tc
);

    ctu_cnt_state_t st, nxt;

    always_comb tc = st.running && step && (st.count == CNT_W'(1));

    always_comb begin
        nxt = st;
        if (st.running && step)
            nxt.count = (st.count == CNT_W'(1)) ? st.reload : st.count - CNT_W'(1);
        if (cfg_we) begin
            if (cfg_acc == ACC_WORD) begin
                nxt.running  = 1'b0;
                nxt.periodic = (cfg_mode == MODE_RATE);
                nxt.wr_hi    = 1'b0;
                nxt.rd_hi    = 1'b0;
                nxt.snap_ok  = 1'b0;
            end else if (cfg_acc == ACC_LATCH && !st.snap_ok) begin
                nxt.snap    = st.count;
                nxt.snap_ok = 1'b1;
                nxt.rd_hi   = 1'b0;
            end
        end
        if (data_we) begin
            if (!st.wr_hi) begin
                nxt.reload[BYTE_W-1:0] = wdata;
                nxt.wr_hi = 1'b1;
            end else begin
                nxt.reload[CNT_W-1:BYTE_W] = wdata;
                nxt.wr_hi = 1'b0;
                if (st.periodic) begin
                    nxt.count   = {wdata, st.reload[BYTE_W-1:0]};
                    nxt.running = 1'b1;
                end
            end
        end
        if (data_re) begin
            nxt.rd_hi = !st.rd_hi;
            if (st.rd_hi) nxt.snap_ok = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end

    always_comb rdata = pick_byte(st.snap_ok ? st.snap : st.count, st.rd_hi);

    AST_RELOAD_ON_TC: assert property (@(posedge clk) disable iff (rst)
        (tc && !data_we && !cfg_we) |=> (st.count == $past(st.reload))) else $error("reload"); // R3

    AST_WORD_CTRL_HALTS: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_acc == ACC_WORD) |=> !st.running) else $error("halt"); // R2

    AST_LOW_BYTE_NO_START: assert property (@(posedge clk) disable iff (rst)
        (data_we && !st.wr_hi && !st.running) |=> !st.running) else $error("early start"); // R2

    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (st.snap_ok && !cfg_we && !data_re) |=> $stable(st.snap)) else $error("snap moved"); // R8

endmodule

// File: rtl/ctu_irq_flags.sv
module ctu_irq_flags
    import ctu_pkg::*;
#(
    parameter int N = NUM_IRQ
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);

    always_ff @(posedge clk) begin
        if (rst) flag <= '0;
        else     flag <= (flag & ~clr) | set;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> flag[i]) else $error("set lost"); // R7
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !set[i]) |=> !flag[i]) else $error("clear lost"); // R6
        AST_STICKY: assert property (@(posedge clk) disable iff (rst)
            (!clr[i] && !set[i]) |=> $stable(flag[i])) else $error("flag moved"); // R5
    end

endmodule

// File: rtl/chained_timer_unit.sv
module chained_timer_unit
    import ctu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq_tick,
    output logic              irq_wrap
);

    ctu_ctrl_t          cfg;
    logic               wr_ctrl;
    logic [NUM_CNT-1:0] tc;
    logic [NUM_CNT-1:0] step;
    logic [BYTE_W-1:0]  cnt_rd [NUM_CNT];
    logic [NUM_IRQ-1:0] irq_clr;
    logic [NUM_IRQ-1:0] irq_flag;

    always_comb cfg     = ctu_ctrl_t'(reg_wdata);
    always_comb wr_ctrl = reg_we && (reg_addr == ADDR_CTRL);
    always_comb irq_clr = (reg_we && reg_addr == ADDR_CLR) ? reg_wdata[NUM_IRQ-1:0] : '0;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        if (i == NUM_CNT - 1) begin : g_pre
            always_comb step[i] = 1'b1;
        end else begin : g_chained
            always_comb step[i] = tc[NUM_CNT-1];
        end

        ctu_counter u_cnt (
            .clk      (clk),
            .rst      (rst),
            .cfg_we   (wr_ctrl && cfg.sel == 2'(i)),
            .cfg_acc  (cfg.acc),
            .cfg_mode (cfg.mode),
            .data_we  (reg_we && reg_addr == ADDR_W'(i)),
            .data_re  (reg_re && reg_addr == ADDR_W'(i)),
            .wdata    (reg_wdata),
            .step     (step[i]),
            .rdata    (cnt_rd[i]),
            .tc       (tc[i])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CNT; i++)
            if (reg_addr == ADDR_W'(i)) reg_rdata = cnt_rd[i];
    end

    ctu_irq_flags #(.N(NUM_IRQ)) u_irq (
        .clk  (clk),
        .rst  (rst),
        .set  (tc[NUM_IRQ-1:0]),
        .clr  (irq_clr),
        .flag (irq_flag)
    );

    always_comb irq_tick = irq_flag[0];
    always_comb irq_wrap = irq_flag[1];

    AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (rst)
        (tc[0] || tc[1]) |-> tc[NUM_CNT-1]) else $error("chain"); // R4

    AST_TICK_FROM_TC: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_tick) |-> $past(tc[0])) else $error("spurious tick"); // R5

endmodule

// File: tb/chained_timer_unit_bench.sv
`timescale 1ns/1ps
module chained_timer_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic       reg_re = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_tick, irq_wrap;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    chained_timer_unit u_chained_timer_unit (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_tick(irq_tick), .irq_wrap(irq_wrap)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // caller is away from the rising edge; write lands on the next edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a; reg_re = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_re = 1'b0;
    endtask

    task automatic load(input logic [7:0] ctrl, input logic [2:0] a, input int v);
        wr(3'd3, ctrl);
        wr(a, v[7:0]);
        wr(a, v[15:8]);
    endtask

    function automatic logic flag_of(input int which);
        return which == 1 ? irq_wrap : irq_tick;
    endfunction

    task automatic wait_flag(input int which, output int t);
        t = -1;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (flag_of(which)) begin t = cyc; break; end
        end
    endtask

    task automatic measure(input int which, input int period, input string req, output int t_last);
        int t0, t1;
        logic [7:0] cbit;
        cbit = (which == 1) ? 8'h02 : 8'h01;
        @(negedge clk);
        wr(3'd4, cbit);
        wait_flag(which, t0);
        wr(3'd4, cbit);
        wait_flag(which, t1);
        chk(t0 >= 0 && t1 - t0 == period, req, t1 - t0, period);
        t_last = t1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk(irq_tick == 0, "R1 tick after reset", irq_tick, 0);
        chk(irq_wrap == 0, "R1 wrap after reset", irq_wrap, 0);
        @(negedge clk);
        rd(3'd0, d); chk(d == 0, "R1 read counter0", d, 0);
        rd(3'd2, d); chk(d == 0, "R1 read counter2", d, 0);
        repeat (30) @(negedge clk);
        chk(irq_tick == 0 && irq_wrap == 0, "R1 stopped after reset", irq_tick, 0);
    endtask

    task automatic t_tick_period();
        int t;
        @(negedge clk);
        load(8'hB4, 3'd2, 5);
        load(8'h34, 3'd0, 3);
        measure(0, 15, "R4 tick period 5x3", t);
        measure(0, 15, "R3 tick period repeats", t);
    endtask

    task automatic t_set_wins();
        int t;
        measure(0, 15, "R3 tick period before race", t);
        wr(3'd4, 8'h01);                       // edge t+1
        while (cyc != t + 14) @(negedge clk);
        wr(3'd4, 8'h01);                       // edge t+15, same as terminal count
        @(negedge clk);
        chk(irq_tick == 1, "R7 set beats clear", irq_tick, 1);
    endtask

    task automatic t_wrap();
        int t;
        @(negedge clk);
        load(8'h74, 3'd1, 4);
        measure(1, 20, "R5 wrap period 5x4", t);
    endtask

    task automatic t_clear_bits();
        int k;
        @(negedge clk);
        for (k = 0; k < 3000; k++) begin
            if (irq_tick && irq_wrap) break;
            @(negedge clk);
        end
        wr(3'd3, 8'hB8);                       // stop prescaler
        repeat (40) @(negedge clk);
        chk(irq_tick == 1 && irq_wrap == 1, "R5 flags held", {irq_tick, irq_wrap}, 3);
        wr(3'd4, 8'h01);
        @(negedge clk);
        chk(irq_tick == 0, "R6 bit0 clears tick", irq_tick, 0);
        chk(irq_wrap == 1, "R6 bit0 leaves wrap", irq_wrap, 1);
        wr(3'd4, 8'h03);
        @(negedge clk);
        chk(irq_wrap == 0 && irq_tick == 0, "R6 0x03 clears both", {irq_tick, irq_wrap}, 0);
    endtask

    task automatic t_half_load();
        int t;
        @(negedge clk);
        load(8'hB4, 3'd2, 5);
        wr(3'd3, 8'h34);
        wr(3'd0, 8'd3);
        wr(3'd4, 8'h01);
        repeat (200) @(negedge clk);
        chk(irq_tick == 0, "R2 low byte alone does not start", irq_tick, 0);
        wr(3'd0, 8'd0);
        measure(0, 15, "R2 starts after high byte", t);
    endtask

    task automatic t_strobe();
        @(negedge clk);
        load(8'h38, 3'd0, 3);
        wr(3'd4, 8'h01);
        repeat (200) @(negedge clk);
        chk(irq_tick == 0, "R9 strobe mode stops tick", irq_tick, 0);
    endtask

    task automatic t_div2();
        int t;
        @(negedge clk);
        load(8'hB4, 3'd2, 2);
        load(8'h34, 3'd0, 2);
        measure(0, 4, "R10 divisor 2 period", t);
        measure(0, 4, "R10 divisor 2 repeats", t);
    endtask

    task automatic t_latch();
        int e;
        logic [7:0] lo, hi;
        @(negedge clk);
        wr(3'd3, 8'hB4);
        wr(3'd2, 8'hE8);
        wr(3'd2, 8'h03);                       // count = 1000 at edge e
        e = cyc;
        while (cyc != e + 9) @(negedge clk);
        wr(3'd3, 8'h80);                       // latch at edge e+10, value 991
        repeat (7) @(negedge clk);
        rd(3'd2, lo);
        repeat (3) @(negedge clk);
        rd(3'd2, hi);
        chk(lo == 8'hDF, "R8 latched low byte", lo, 8'hDF);
        chk(hi == 8'h03, "R8 latched high byte", hi, 8'h03);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_tick_period();
        t_set_wins();
        t_wrap();
        t_clear_bits();
        t_half_load();
        t_strobe();
        t_div2();
        t_latch();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(150000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule